// File: doc/BRIEF.md
# UART Receive Status with Error-Tagged FIFO

This block is the receive-side status logic of a serial port. A bit-level receiver in front of it delivers each finished character with three error indications (parity, framing, break), plus a marking-line level and a start-bit strobe. The block stores the characters, keeps their error tags, and reports them through an 8-bit line status word. The CPU side uses a data-read strobe to pop characters and a status-read strobe to acknowledge status.

A mode input selects one of two storage modes. With the FIFO off, one holding register keeps a single character, and the error flags are sticky until the status word is read. With the FIFO on, a 16-entry queue keeps the tags beside each character. The tags show in the status word only while their character is at the head. An aggregate error bit tracks whether any stored character carries a tag.

A break stores one all-zero character. After that, the input is closed until the line returns to marking and a new start bit arrives. Changing the mode flushes all storage and status.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `lsr_o` is 8'h00 and `data_o` is 8'h00.
- R2: With `fifo_en_i`=0, an accepted character sets `lsr_o[0]` (data ready) and appears on `data_o`. A `data_rd_i` pulse clears `lsr_o[0]`. A character that arrives while the holding register is full is dropped and sets `lsr_o[1]` (overrun). `lsr_o[1]` clears on a `status_rd_i` pulse.
- R3: With `fifo_en_i`=0, a character's parity, framing and break indications set `lsr_o[2]`, `lsr_o[3]` and `lsr_o[4]`. These bits stay set after the data is read and clear on a `status_rd_i` pulse.
- R4: A character with the break indication is stored as 8'h00, whatever its data bits are. Further characters are ignored until `line_high_i` has been seen and then a `start_bit_i` pulse arrives. A start pulse without a prior marking level does not reopen the input.
- R5: With `fifo_en_i`=1, up to 16 characters are stored and read back in arrival order on `data_o`.
- R6: With `fifo_en_i`=1, `lsr_o[4:2]` show the break, framing and parity tags of the head character only. Popping the head exposes the tags of the next entry.
- R7: With `fifo_en_i`=1, a character arriving while 16 are stored is dropped and sets `lsr_o[1]`.
- R8: With `fifo_en_i`=1, `lsr_o[7]` is 1 while any stored character carries a tag. A status read does not clear it while such an entry remains. After the last tagged entry is popped, it stays 1 until the next status read.
- R9: With `fifo_en_i`=0, `lsr_o[7]` reads 0.
- R10: A change of `fifo_en_i` empties the storage and clears every bit of `lsr_o` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects the 16-entry queue, 0 selects the single holding register |
| char_valid_i | input | 1 | Strobe: a character has been received |
| char_data_i | input | 8 | Received data bits |
| char_perr_i | input | 1 | Parity error indication for this character |
| char_ferr_i | input | 1 | Missing stop bit indication for this character |
| char_brk_i | input | 1 | Break indication: line held low for a full character time |
| line_high_i | input | 1 | Serial line is in the marking state |
| start_bit_i | input | 1 | Strobe: a valid start bit has been detected |
| data_rd_i | input | 1 | Strobe: pop the head character |
| status_rd_i | input | 1 | Strobe: status word is being read |
| data_o | output | 8 | Head character, 0 when empty |
| lsr_o | output | 8 | Status: [0] ready, [1] overrun, [2] parity, [3] framing, [4] break, [7] queue error, [6:5] zero |

## Verification
A wrong read or write pointer shows up as a wrong byte on `data_o` at the first pop after the error. Tags that slip by one entry show up as status bits that appear one pop early or late. The count of tagged entries is visible only through `lsr_o[7]`: a counter that drifts either drops the bit while a tagged byte is still queued, or keeps it set after the queue is drained and status has been read. The bench checks both cases right after the relevant pop and status read. A stuck break gate shows within one character, as a missing or unexpected data-ready bit.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       pe;
    logic       fe;
    logic       bi;
  } rx_entry_t;

  typedef enum logic [1:0] {
    GATE_OPEN       = 2'd0,
    GATE_WAIT_MARK  = 2'd1,
    GATE_WAIT_START = 2'd2
  } gate_state_e;

  localparam int LSR_DR   = 0;
  localparam int LSR_OE   = 1;
  localparam int LSR_PE   = 2;
  localparam int LSR_FE   = 3;
  localparam int LSR_BI   = 4;
  localparam int LSR_FERR = 7;

  function automatic logic entry_tagged(rx_entry_t e);
    return e.pe | e.fe | e.bi;
  endfunction

endpackage

// File: rtl/rxs_break_gate.sv
module rxs_break_gate
  import uart_rxs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic char_valid_i,
  input  logic char_brk_i,
  input  logic line_high_i,
  input  logic start_bit_i,
  output logic pass_o,
  output logic open_o
);

  gate_state_e state_q, state_d;

  assign open_o = (state_q == GATE_OPEN);
  assign pass_o = char_valid_i & open_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_OPEN:       if (pass_o && char_brk_i) state_d = GATE_WAIT_MARK;
      GATE_WAIT_MARK:  if (line_high_i)          state_d = GATE_WAIT_START;
      GATE_WAIT_START: if (start_bit_i)          state_d = GATE_OPEN;
      default:                                   state_d = GATE_OPEN;
    endcase
    if (flush_i) state_d = GATE_OPEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GATE_OPEN;
    else         state_q <= state_d;
  end

  // R4: reopening needs the marking level first
  a_r4_reopen_after_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GATE_WAIT_MARK && !flush_i) |=> (state_q != GATE_OPEN));

endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic                           single_i,
  input  logic                           push_i,
  input  rx_entry_t                      push_entry_i,
  input  logic                           pop_i,
  output rx_entry_t                      head_o,
  output logic                           empty_o,
  output logic                           full_o,
  output logic [$clog2(DEPTH+1)-1:0]     err_cnt_o,
  output logic [$clog2(DEPTH+1)-1:0]     err_cnt_nxt_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q, err_cnt_q;
  logic             pop_ok, push_tag, pop_tag;

  assign empty_o  = (cnt_q == '0);
  assign full_o   = single_i ? !empty_o : (cnt_q == CNT_W'(DEPTH));
  assign head_o   = mem_q[rd_ptr_q];
  assign pop_ok   = pop_i & !empty_o;
  assign push_tag = push_i & entry_tagged(push_entry_i);
  assign pop_tag  = pop_ok & entry_tagged(head_o);

  assign err_cnt_o     = err_cnt_q;
  assign err_cnt_nxt_o = flush_i ? '0 :
                         err_cnt_q + CNT_W'(push_tag) - CNT_W'(pop_tag);

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= push_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q  <= '0;
      wr_ptr_q  <= '0;
      cnt_q     <= '0;
      err_cnt_q <= '0;
    end else if (flush_i) begin
      rd_ptr_q  <= '0;
      wr_ptr_q  <= '0;
      cnt_q     <= '0;
      err_cnt_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q     <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_ok);
      err_cnt_q <= err_cnt_nxt_o;
    end
  end

  // R7: occupancy never exceeds the configured depth
  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R8: tagged-entry count never exceeds occupancy
  a_r8_err_le_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_q <= cnt_q);

  // R5: a pop without push lowers occupancy by one
  a_r5_pop_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_ok && !push_i && !flush_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       char_valid_i,
  input  logic [7:0] char_data_i,
  input  logic       char_perr_i,
  input  logic       char_ferr_i,
  input  logic       char_brk_i,
  input  logic       line_high_i,
  input  logic       start_bit_i,
  input  logic       data_rd_i,
  input  logic       status_rd_i,
  output logic [7:0] data_o,
  output logic [7:0] lsr_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             mode_q, flush;
  logic             pass, gate_open, can_push, push, pop, ovr_set;
  rx_entry_t        entry, head;
  logic             empty, full;
  logic [CNT_W-1:0] err_cnt, err_cnt_nxt;
  logic             pe_q, fe_q, bi_q, ovr_q, ferr_q;
  logic [2:0]       tag_view;

  assign flush = (fifo_en_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= fifo_en_i;
  end

  rxs_break_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .char_valid_i (char_valid_i),
    .char_brk_i   (char_brk_i),
    .line_high_i  (line_high_i),
    .start_bit_i  (start_bit_i),
    .pass_o       (pass),
    .open_o       (gate_open)
  );

  always_comb begin
    entry.data = char_brk_i ? 8'h00 : char_data_i;
    entry.pe   = char_perr_i;
    entry.fe   = char_ferr_i;
    entry.bi   = char_brk_i;
  end

  assign pop      = data_rd_i & !empty & !flush;
  assign can_push = !full | pop;
  assign push     = pass & can_push & !flush;
  assign ovr_set  = pass & !can_push & !flush;

  rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush),
    .single_i      (!fifo_en_i),
    .push_i        (push),
    .push_entry_i  (entry),
    .pop_i         (pop),
    .head_o        (head),
    .empty_o       (empty),
    .full_o        (full),
    .err_cnt_o     (err_cnt),
    .err_cnt_nxt_o (err_cnt_nxt)
  );

  // sticky flags: set beats clear when both land together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bi_q   <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else if (flush) begin
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bi_q   <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      pe_q   <= (push & !fifo_en_i & entry.pe) | (pe_q & !status_rd_i);
      fe_q   <= (push & !fifo_en_i & entry.fe) | (fe_q & !status_rd_i);
      bi_q   <= (push & !fifo_en_i & entry.bi) | (bi_q & !status_rd_i);
      ovr_q  <= ovr_set | (ovr_q & !status_rd_i);
      ferr_q <= fifo_en_i & ((err_cnt_nxt != '0) | (ferr_q & !status_rd_i));
    end
  end

  always_comb begin
    if (mode_q) tag_view = empty ? 3'b000 : {head.bi, head.fe, head.pe};
    else        tag_view = {bi_q, fe_q, pe_q};
  end

  always_comb begin
    lsr_o                    = 8'h00;
    lsr_o[LSR_DR]            = !empty;
    lsr_o[LSR_OE]            = ovr_q;
    lsr_o[LSR_BI:LSR_PE]     = tag_view;
    lsr_o[LSR_FERR]          = ferr_q;
  end

  assign data_o = empty ? 8'h00 : head.data;

  // R10: a mode change leaves nothing visible on the next cycle
  a_r10_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (lsr_o == 8'h00));

  // R8: a queued tagged entry always raises the aggregate bit
  a_r8_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && fifo_en_i && err_cnt != '0) |-> lsr_o[LSR_FERR]);

  // R9: aggregate bit stays low in single-register mode
  a_r9_no_ferr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !fifo_en_i) |-> !lsr_o[LSR_FERR]);

  // R4: storing a break closes the input
  a_r4_break_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && entry.bi) |=> !gate_open);

  // R2: a dropped character is always reported
  a_r2_overrun_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set |=> lsr_o[LSR_OE]);

endmodule

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic       cv = 1'b0;
  logic [7:0] cd = 8'h00;
  logic       cpe = 1'b0, cfe = 1'b0, cbi = 1'b0;
  logic       lh = 1'b0, sb = 1'b0;
  logic       drd = 1'b0, srd = 1'b0;
  logic [7:0] dout, lsr;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] d; logic [2:0] tags; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  uart_rx_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en),
    .char_valid_i(cv), .char_data_i(cd), .char_perr_i(cpe),
    .char_ferr_i(cfe), .char_brk_i(cbi), .line_high_i(lh),
    .start_bit_i(sb), .data_rd_i(drd), .status_rd_i(srd),
    .data_o(dout), .lsr_o(lsr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: one-cycle character strobe; records expectation when accepted
  task automatic send(logic [7:0] d, logic pe, logic fe, logic bi, bit acc);
    @(negedge clk);
    cv = 1'b1; cd = d; cpe = pe; cfe = fe; cbi = bi;
    @(negedge clk);
    cv = 1'b0; cpe = 1'b0; cfe = 1'b0; cbi = 1'b0;
    if (acc) sb_q.push_back('{d: (bi ? 8'h00 : d), tags: {bi, fe, pe}});
  endtask

  task automatic status_read();
    @(negedge clk); srd = 1'b1;
    @(negedge clk); srd = 1'b0;
  endtask

  task automatic pulse_mark();
    @(negedge clk); lh = 1'b1;
    @(negedge clk); lh = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); sb = 1'b1;
    @(negedge clk); sb = 1'b0;
  endtask

  // monitor: compare head against scoreboard, then pop
  task automatic pop_check(string req);
    exp_t e;
    e = sb_q.pop_front();
    chk(req, dout, e.d);
    if (fifo_en) chk({req, " tags"}, lsr[4:2], e.tags);
    @(negedge clk); drd = 1'b1;
    @(negedge clk); drd = 1'b0;
  endtask

  task automatic set_mode(logic m);
    @(negedge clk); fifo_en = m;
    sb_q.delete();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lsr", lsr, 8'h00);
    chk("R1 data", dout, 8'h00);

    // single-register mode
    send(8'h5A, 0, 0, 0, 1);
    chk("R2 ready", lsr[0], 1'b1);
    send(8'h33, 0, 0, 0, 0);
    chk("R2 overrun", lsr[1], 1'b1);
    chk("R2 kept", dout, 8'h5A);
    status_read();
    chk("R2 overrun cleared", lsr[1], 1'b0);
    pop_check("R2 data");
    chk("R2 ready cleared", lsr[0], 1'b0);

    send(8'h11, 0, 1, 0, 1);
    pop_check("R3 data");
    chk("R3 framing sticky", lsr[3], 1'b1);
    chk("R9 no queue error", lsr[7], 1'b0);
    status_read();
    chk("R3 flags cleared", lsr[4:2], 3'b000);

    // break handling
    send(8'hFF, 0, 0, 1, 1);
    chk("R4 break flag", lsr[4], 1'b1);
    pop_check("R4 zero char");
    send(8'h77, 0, 0, 0, 0);
    chk("R4 closed", lsr[0], 1'b0);
    pulse_start();
    send(8'h78, 0, 0, 0, 0);
    chk("R4 start without mark", lsr[0], 1'b0);
    pulse_mark();
    pulse_start();
    send(8'h79, 0, 0, 0, 1);
    chk("R4 reopened", lsr[0], 1'b1);
    pop_check("R4 next char");
    status_read();

    // flush on mode change
    send(8'h42, 1, 0, 0, 1);
    set_mode(1'b1);
    chk("R10 into fifo", lsr, 8'h00);

    // tagged entries in the queue
    send(8'hA1, 0, 0, 0, 1);
    send(8'hA2, 1, 0, 0, 1);
    send(8'hA3, 0, 0, 0, 1);
    send(8'hA4, 0, 1, 0, 1);
    chk("R8 set", lsr[7], 1'b1);
    pop_check("R6 clean head");
    status_read();
    chk("R8 held by queue", lsr[7], 1'b1);
    pop_check("R6 parity head");
    pop_check("R6 clean after parity");
    pop_check("R6 framing head");
    chk("R5 empty", lsr[0], 1'b0);
    chk("R8 held until read", lsr[7], 1'b1);
    status_read();
    chk("R8 cleared", lsr[7], 1'b0);

    // fill and overflow
    for (int i = 0; i < 16; i++) send(8'h80 + 8'(i), (i == 7), 0, 0, 1);
    chk("R5 ready", lsr[0], 1'b1);
    chk("R7 no overrun yet", lsr[1], 1'b0);
    send(8'hEE, 0, 0, 0, 0);
    chk("R7 overrun", lsr[1], 1'b1);
    for (int i = 0; i < 16; i++) pop_check("R5 order");
    chk("R5 drained", lsr[0], 1'b0);
    status_read();
    chk("R7 cleared", lsr[1], 1'b0);

    // flush back to single mode
    send(8'h21, 0, 1, 0, 1);
    send(8'h22, 0, 0, 0, 1);
    send(8'h23, 0, 0, 0, 0);
    send(8'h24, 0, 0, 0, 0);
    send(8'h25, 0, 0, 0, 0);
    set_mode(1'b0);
    chk("R10 into single", lsr, 8'h00);
    send(8'h66, 1, 0, 0, 1);
    chk("R9 zero in single", lsr[7], 1'b0);
    pop_check("R9 data");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

endmodule